// File: doc/BRIEF.md
# Capability load permission filter

This block sits on the path that returns a capability from memory. It receives the permissions of the authorizing capability along with the loaded value's tag, sealed flag, permission set and remaining payload bits. It registers the result with one cycle of latency. The final tag is gated by the authority's capability permission.

The read-only restriction depends on the loaded data, so the block does not mask the permissions on the load path. It registers one deferred strip bit next to the raw permissions. That bit means that write and load-mutable must be removed. A separate inspection output applies the bit through the permission reduction rules. That output is used when the permissions are read or the capability is dereferenced. A combinational store-side tag gate covers atomic capability operations. These use the same rule: without the capability permission, the stored tag is zero.

Permission vectors are 7 bits wide: bit0 read, bit1 write, bit2 capability, bit3 load-mutable, bit4 execute, bit5 system-register access, bit6 mode.

Top module: `cap_load_perm_filter`

## Requirements
- R1: One cycle after a cycle with `ld_valid_i` high, `tag_o` equals `mem_tag_i` AND `auth_perm_i[2]`, and `ld_valid_o` is high for that one cycle.
- R2: `strip_o` is high exactly when the registered load had a final tag of 1, was unsealed, and `auth_perm_i[3]` was 0.
- R3: For an untagged result (`tag_o` = 0), `insp_perm_o` equals the loaded permissions unchanged.
- R4: For a sealed loaded capability, `insp_perm_o` equals the loaded permissions unchanged.
- R5: When `strip_o` is 1, `insp_perm_o` is the loaded permissions with write and load-mutable cleared, and then reduced in this order. Capability and execute are cleared without read. Execute is cleared when read and execute are set but capability and write are not. Mode is cleared without execute. Load-mutable is cleared without capability. When `NARROW_FMT`=1, write is cleared when capability is set without load-mutable. System access is cleared unless read, write, capability, load-mutable and execute are all set.
- R6: A tagged, unsealed load through an authority that holds load-mutable gives `insp_perm_o` equal to the loaded permissions, with no reduction.
- R7: `perm_raw_o`, `sealed_o` and `payload_o` are the loaded fields registered unchanged, whatever the value of `strip_o`.
- R8: `st_tag_o` equals `st_tag_i` AND `auth_perm_i[2]`, combinationally.
- R9: During reset and after it, every registered output is 0 until the first load.
- R10: While `ld_valid_i` is low, all registered outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_valid_i | input | 1 | Loaded data present this cycle |
| auth_perm_i | input | 7 | Authorizing capability permissions |
| mem_tag_i | input | 1 | Tag read from memory |
| mem_sealed_i | input | 1 | Loaded capability is sealed |
| mem_perm_i | input | 7 | Loaded permission field |
| mem_payload_i | input | PAYLOAD_W | Other loaded capability bits |
| st_tag_i | input | 1 | Tag of a capability being stored |
| ld_valid_o | output | 1 | Registered result valid |
| tag_o | output | 1 | Final tag |
| sealed_o | output | 1 | Registered sealed flag |
| perm_raw_o | output | 7 | Unmasked forwarded permissions |
| strip_o | output | 1 | Deferred strip-write/load-mutable bit |
| payload_o | output | PAYLOAD_W | Registered payload |
| insp_perm_o | output | 7 | Permissions as seen at inspection |
| st_tag_o | output | 1 | Tag to be written to memory |

## Verification
The hardest case to reach is a strip where the reduction removes more than write and load-mutable. Examples are execute being removed without capability and write, mode following execute, and capability disappearing because read is missing. A random sweep that only covers full permission sets never reaches these. Hand-built vectors aim at each reduction rule through an authority that lacks load-mutable. A random sweep then compares the inspection output against a bench model. That model applies the mask and iterates the rules to a fixed point at load time.

// File: rtl/cap_ld_pkg.sv
package cap_ld_pkg;
  typedef struct packed {
    logic mode;
    logic sys;
    logic exe;
    logic lmut;
    logic cap;
    logic wr;
    logic rd;
  } perm_t;

  localparam int PERM_W = $bits(perm_t);
endpackage

// File: rtl/cap_perm_reduce.sv
module cap_perm_reduce
  import cap_ld_pkg::*;
#(
  parameter bit NARROW_FMT = 1'b1
) (
  input  perm_t perm_i,
  output perm_t perm_o
);
  perm_t s0, s1;
  logic  narrow_wr_clr;

  // rules applied in an order that needs no second pass
  always_comb begin
    s0 = perm_i;
    if (!s0.rd) begin
      s0.cap = 1'b0;
      s0.exe = 1'b0;
    end
    if (s0.exe && s0.rd && !s0.cap && !s0.wr) s0.exe = 1'b0;
    if (!s0.exe) s0.mode = 1'b0;
    if (!s0.cap) s0.lmut = 1'b0;
  end

  generate
    if (NARROW_FMT) begin : g_narrow
      assign narrow_wr_clr = s0.cap && !s0.lmut;
    end else begin : g_wide
      assign narrow_wr_clr = 1'b0;
    end
  endgenerate

  always_comb begin
    s1 = s0;
    if (narrow_wr_clr) s1.wr = 1'b0;
    if (!(s1.rd && s1.wr && s1.cap && s1.lmut && s1.exe)) s1.sys = 1'b0;
    perm_o = s1;
  end
endmodule

// File: rtl/cap_ld_filter.sv
module cap_ld_filter
  import cap_ld_pkg::*;
(
  input  perm_t auth_i,
  input  logic  mem_tag_i,
  input  logic  mem_sealed_i,
  input  logic  st_tag_i,
  output logic  tag_o,
  output logic  strip_o,
  output logic  st_tag_o
);
  logic unused_auth;
  assign unused_auth = ^{auth_i.rd, auth_i.wr, auth_i.exe, auth_i.sys, auth_i.mode};

  assign tag_o    = mem_tag_i & auth_i.cap;
  assign strip_o  = ~auth_i.lmut & tag_o & ~mem_sealed_i;
  assign st_tag_o = st_tag_i & auth_i.cap;
endmodule

// File: rtl/cap_ld_stage.sv
module cap_ld_stage
  import cap_ld_pkg::*;
#(
  parameter int PAYLOAD_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 tag_i,
  input  logic                 sealed_i,
  input  logic                 strip_i,
  input  perm_t                perm_i,
  input  logic [PAYLOAD_W-1:0] payload_i,
  output logic                 valid_o,
  output logic                 tag_o,
  output logic                 sealed_o,
  output logic                 strip_o,
  output perm_t                perm_o,
  output logic [PAYLOAD_W-1:0] payload_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      tag_o     <= 1'b0;
      sealed_o  <= 1'b0;
      strip_o   <= 1'b0;
      perm_o    <= '0;
      payload_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        tag_o     <= tag_i;
        sealed_o  <= sealed_i;
        strip_o   <= strip_i;
        perm_o    <= perm_i;
        payload_o <= payload_i;
      end
    end
  end
endmodule

// File: rtl/cap_ld_inspect.sv
module cap_ld_inspect
  import cap_ld_pkg::*;
#(
  parameter bit NARROW_FMT = 1'b1
) (
  input  perm_t perm_i,
  input  logic  strip_i,
  output perm_t perm_o
);
  perm_t masked, reduced;

  always_comb begin
    masked      = perm_i;
    masked.wr   = 1'b0;
    masked.lmut = 1'b0;
  end

  cap_perm_reduce #(.NARROW_FMT(NARROW_FMT)) u_reduce (
    .perm_i(masked),
    .perm_o(reduced)
  );

  assign perm_o = strip_i ? reduced : perm_i;
endmodule

// File: rtl/cap_load_perm_filter.sv
module cap_load_perm_filter
  import cap_ld_pkg::*;
#(
  parameter int PAYLOAD_W  = 16,
  parameter bit NARROW_FMT = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ld_valid_i,
  input  logic [PERM_W-1:0]    auth_perm_i,
  input  logic                 mem_tag_i,
  input  logic                 mem_sealed_i,
  input  logic [PERM_W-1:0]    mem_perm_i,
  input  logic [PAYLOAD_W-1:0] mem_payload_i,
  input  logic                 st_tag_i,
  output logic                 ld_valid_o,
  output logic                 tag_o,
  output logic                 sealed_o,
  output logic [PERM_W-1:0]    perm_raw_o,
  output logic                 strip_o,
  output logic [PAYLOAD_W-1:0] payload_o,
  output logic [PERM_W-1:0]    insp_perm_o,
  output logic                 st_tag_o
);
  perm_t auth, raw_q, insp;
  logic  tag_d, strip_d;

  assign auth = perm_t'(auth_perm_i);

  cap_ld_filter u_filter (
    .auth_i      (auth),
    .mem_tag_i   (mem_tag_i),
    .mem_sealed_i(mem_sealed_i),
    .st_tag_i    (st_tag_i),
    .tag_o       (tag_d),
    .strip_o     (strip_d),
    .st_tag_o    (st_tag_o)
  );

  cap_ld_stage #(.PAYLOAD_W(PAYLOAD_W)) u_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (ld_valid_i),
    .tag_i    (tag_d),
    .sealed_i (mem_sealed_i),
    .strip_i  (strip_d),
    .perm_i   (perm_t'(mem_perm_i)),
    .payload_i(mem_payload_i),
    .valid_o  (ld_valid_o),
    .tag_o    (tag_o),
    .sealed_o (sealed_o),
    .strip_o  (strip_o),
    .perm_o   (raw_q),
    .payload_o(payload_o)
  );

  cap_ld_inspect #(.NARROW_FMT(NARROW_FMT)) u_inspect (
    .perm_i (raw_q),
    .strip_i(strip_o),
    .perm_o (insp)
  );

  assign perm_raw_o  = raw_q;
  assign insp_perm_o = insp;
endmodule

// File: rtl/cap_load_perm_filter_chk.sv
module cap_load_perm_filter_chk #(
  parameter int PERM_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ld_valid_i,
  input logic [PERM_W-1:0] auth_perm_i,
  input logic              mem_tag_i,
  input logic [PERM_W-1:0] mem_perm_i,
  input logic              st_tag_i,
  input logic              tag_o,
  input logic              sealed_o,
  input logic [PERM_W-1:0] perm_raw_o,
  input logic              strip_o,
  input logic [PERM_W-1:0] insp_perm_o,
  input logic              st_tag_o
);
  a_r1_tag_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i |=> tag_o == $past(mem_tag_i && auth_perm_i[2]));

  a_r2_strip_needs_live_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strip_o |-> tag_o && !sealed_o);

  a_r3_untagged_unchanged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tag_o |-> insp_perm_o == perm_raw_o);

  a_r4_sealed_unchanged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sealed_o |-> insp_perm_o == perm_raw_o);

  a_r5_strip_removes_wr_lm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strip_o |-> !insp_perm_o[1] && !insp_perm_o[3] && !insp_perm_o[5]);

  a_r7_raw_forwarded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i |=> perm_raw_o == $past(mem_perm_i));

  a_r8_store_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_tag_o |-> st_tag_i && auth_perm_i[2]);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_valid_i |=> $stable(tag_o) && $stable(perm_raw_o) && $stable(strip_o));
endmodule

bind cap_load_perm_filter cap_load_perm_filter_chk #(.PERM_W(7)) u_chk (.*);

// File: tb/tb_cap_load_perm_filter.sv
`timescale 1ns/1ps
module tb_cap_load_perm_filter;
  localparam int PW = 16;
  localparam int NV = 9;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ld_valid_i = 1'b0, mem_tag_i = 1'b0, mem_sealed_i = 1'b0, st_tag_i = 1'b0;
  logic [6:0] auth_perm_i = '0, mem_perm_i = '0;
  logic [PW-1:0] mem_payload_i = '0;
  logic ld_valid_o, tag_o, sealed_o, strip_o, st_tag_o;
  logic [6:0] perm_raw_o, insp_perm_o;
  logic [PW-1:0] payload_o;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  cap_load_perm_filter #(.PAYLOAD_W(PW), .NARROW_FMT(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .ld_valid_i(ld_valid_i), .auth_perm_i(auth_perm_i),
    .mem_tag_i(mem_tag_i), .mem_sealed_i(mem_sealed_i), .mem_perm_i(mem_perm_i),
    .mem_payload_i(mem_payload_i), .st_tag_i(st_tag_i), .ld_valid_o(ld_valid_o),
    .tag_o(tag_o), .sealed_o(sealed_o), .perm_raw_o(perm_raw_o), .strip_o(strip_o),
    .payload_o(payload_o), .insp_perm_o(insp_perm_o), .st_tag_o(st_tag_o)
  );

  // {auth, tag, sealed, perm, exp_tag, exp_strip, exp_insp}
  localparam logic [24:0] VEC [NV] = '{
    {7'h3F, 1'b1, 1'b0, 7'h3F, 1'b1, 1'b0, 7'h3F},
    {7'h37, 1'b1, 1'b0, 7'h3F, 1'b1, 1'b1, 7'h15},
    {7'h37, 1'b1, 1'b1, 7'h3F, 1'b1, 1'b0, 7'h3F},
    {7'h37, 1'b0, 1'b0, 7'h7F, 1'b0, 1'b0, 7'h7F},
    {7'h3B, 1'b1, 1'b0, 7'h0F, 1'b0, 1'b0, 7'h0F},
    {7'h37, 1'b1, 1'b0, 7'h53, 1'b1, 1'b1, 7'h01},
    {7'h00, 1'b1, 1'b0, 7'h0E, 1'b0, 1'b0, 7'h0E},
    {7'h37, 1'b1, 1'b0, 7'h0E, 1'b1, 1'b1, 7'h00},
    {7'h37, 1'b1, 1'b0, 7'h57, 1'b1, 1'b1, 7'h55}
  };

  // bench model: mask, then apply rules until nothing changes
  function automatic logic [6:0] model_reduce(input logic [6:0] p);
    logic [6:0] q;
    q = p;
    for (int it = 0; it < 8; it++) begin
      if (!q[0]) q[2] = 1'b0;
      if (!q[0]) q[4] = 1'b0;
      if (q[4] && q[0] && !q[2] && !q[1]) q[4] = 1'b0;
      if (!q[4]) q[6] = 1'b0;
      if (!q[2]) q[3] = 1'b0;
      if (q[2] && !q[3]) q[1] = 1'b0;
      if (q[4:0] != 5'h1F) q[5] = 1'b0;
    end
    return q;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [6:0] a, input logic t, input logic s,
                         input logic [6:0] p, input logic [PW-1:0] pl);
    @(negedge clk);
    auth_perm_i = a; mem_tag_i = t; mem_sealed_i = s; mem_perm_i = p;
    mem_payload_i = pl; ld_valid_i = 1'b1;
    @(negedge clk);
    ld_valid_i = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [6:0] a, p, ei;
    logic t, s, et, es;
    // R9 reset
    #12;
    chk("R9 valid", ld_valid_o, 0);
    chk("R9 tag", tag_o, 0);
    chk("R9 strip", strip_o, 0);
    chk("R9 insp", insp_perm_o, 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk("R9 tag after release", tag_o, 0);
    chk("R9 raw after release", perm_raw_o, 0);

    for (int i = 0; i < NV; i++) begin
      do_load(VEC[i][24:18], VEC[i][17], VEC[i][16], VEC[i][15:9], PW'(i * 16'h1111));
      chk("R1 tag", tag_o, VEC[i][8]);
      chk("R1 valid", ld_valid_o, 1);
      chk("R2 strip", strip_o, VEC[i][7]);
      chk("R5 R3 R4 R6 insp", insp_perm_o, VEC[i][6:0]);
      chk("R7 raw", perm_raw_o, VEC[i][15:9]);
      chk("R7 sealed", sealed_o, VEC[i][16]);
      chk("R7 payload", payload_o, PW'(i * 16'h1111));
    end
    @(negedge clk);
    chk("R1 valid pulse", ld_valid_o, 0);

    // R10 hold: inputs move while valid low
    do_load(7'h37, 1'b1, 1'b0, 7'h3F, 16'hBEEF);
    @(negedge clk);
    auth_perm_i = 7'h3F; mem_tag_i = 1'b0; mem_sealed_i = 1'b1; mem_perm_i = 7'h00;
    mem_payload_i = 16'h0;
    repeat (3) @(negedge clk);
    chk("R10 tag", tag_o, 1);
    chk("R10 strip", strip_o, 1);
    chk("R10 raw", perm_raw_o, 7'h3F);
    chk("R10 insp", insp_perm_o, 7'h15);
    chk("R10 payload", payload_o, 16'hBEEF);

    // R8 store-side tag
    auth_perm_i = 7'h3F; st_tag_i = 1'b1; #1;
    chk("R8 store tag kept", st_tag_o, 1);
    auth_perm_i = 7'h3B; #1;
    chk("R8 store tag cleared", st_tag_o, 0);
    st_tag_i = 1'b0; auth_perm_i = 7'h3F; #1;
    chk("R8 store untagged", st_tag_o, 0);

    // R5 random sweep: inspection equals masking at load time
    for (int n = 0; n < 400; n++) begin
      a = 7'($urandom); p = 7'($urandom);
      t = 1'($urandom); s = 1'($urandom);
      et = t & a[2];
      es = et & ~s & ~a[3];
      ei = es ? model_reduce(p & 7'b1110101) : p;
      do_load(a, t, s, p, 16'($urandom));
      chk("R1 random tag", tag_o, et);
      chk("R2 random strip", strip_o, es);
      chk("R5 random insp", insp_perm_o, ei);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule